// File: doc/BRIEF.md
# Address-Window Traffic Class Mapper

This block labels upstream memory requests that start on a parallel bus. Each request address is checked against a small set of programmable address windows. Every window has a base page, a limit page, an enable bit and a traffic class (TC). A request inside an enabled window takes that window's TC. A request outside every enabled window takes TC0. The chosen TC then goes through a software-written TC-to-virtual-channel table, which selects one of two virtual channels (VC). When the second channel is switched off, every request goes to VC0. The TC label is still applied in that case, so windows can be used without a second channel.

A request is presented for one cycle with its address and a flag that marks it as a memory access. The label appears on the outputs one clock later. Window descriptors, the TC-to-VC table and the second-channel enable are written through simple write strobes. A combinational flag reports an inconsistent setup: the second channel is on, but no enabled window carries a TC that the table routes to it.

Top module: `tcw_mapper`

## Requirements
- R1: After a synchronous active-low reset, all windows are disabled, the TC-to-VC table is all zero and the second channel is off. A memory request then returns TC0, VC0 and no hit, and `cfg_err` is 0.
- R2: `out_valid` is high exactly one cycle after a cycle with `req_valid` high. When `out_valid` is low, `out_tc`, `out_vc` and `out_hit` are 0.
- R3: A window matches when base page <= address bits [ADDR_W-1:12] <= limit page. The bounds are inclusive at 4 KB granularity. A match sets `out_hit` and returns the window's TC.
- R4: A memory request that matches no enabled window returns TC0 with `out_hit` = 0.
- R5: When several enabled windows match, the window with the lowest index provides the TC.
- R6: A request with `req_is_mem` = 0 always returns TC0, VC0 and `out_hit` = 0.
- R7: With the second channel on, `out_vc` equals bit `out_tc` of the TC-to-VC table (1 = VC1).
- R8: With the second channel off, `out_vc` is 0 for every request.
- R9: A disabled window never matches. Enabled windows still label the TC while the second channel is off.
- R10: `cfg_err` is 1 exactly when the second channel is on and no enabled window has a TC whose table bit is 1. It reflects a configuration write from the cycle after that write.
- R11: A request presented in the same cycle as a configuration write is classified with the configuration in place before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Request byte address |
| req_is_mem | input | 1 | 1 = memory request, 0 = any other command |
| cfg_we | input | 1 | Write one window descriptor |
| cfg_win | input | WIN_IDX_W | Index of the window being written |
| cfg_base | input | ADDR_W-12 | Base page (address >> 12) |
| cfg_limit | input | ADDR_W-12 | Limit page, inclusive |
| cfg_en | input | 1 | Window enable |
| cfg_tc | input | 3 | Window traffic class |
| map_we | input | 1 | Write the TC-to-VC table and the second-channel enable |
| map_vec | input | 8 | Bit n = 1 routes TCn to VC1 |
| map_vc1_en | input | 1 | Second-channel enable |
| out_valid | output | 1 | Result valid |
| out_tc | output | 3 | Traffic class label |
| out_vc | output | 1 | Virtual channel index |
| out_hit | output | 1 | Request hit an enabled window |
| cfg_err | output | 1 | Second channel on with no window routed to it |

## Verification
The bench builds the block with its defaults: four windows, 32-bit addresses and 4 KB pages. Four windows are enough to program two overlapping windows, a single-page window and a disabled window all at once. Then one table of addresses covers both page bounds, the overlap priority, a disabled hit and the top of the address space. Directed steps then switch the second channel off, clear the table so that `cfg_err` rises, and collide a window rewrite with a request in the same cycle.

// File: rtl/tcw_pkg.sv
// Package: shared widths and types for the traffic class mapper.
// Assumes: traffic classes are 3 bits, so the TC-to-VC table holds 8 entries.
package tcw_pkg;
    localparam int TC_W   = 3;
    localparam int NUM_TC = 1 << TC_W;
    typedef logic [TC_W-1:0] tc_t;
endpackage

// File: rtl/tcw_win_regs.sv
// Module: tcw_win_regs
// Holds the window descriptors: enable, base page, limit page and TC.
// Assumes: a single write port updates one whole descriptor per cycle.
// All windows come out of reset disabled.
module tcw_win_regs
    import tcw_pkg::*;
#(
    parameter int NUM_WIN   = 4,
    parameter int PG_W      = 20,
    parameter int WIN_IDX_W = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [WIN_IDX_W-1:0]           wr_idx,
    input  logic [PG_W-1:0]                wr_base,
    input  logic [PG_W-1:0]                wr_limit,
    input  logic                           wr_enable,
    input  tc_t                            wr_tc,
    output logic [NUM_WIN-1:0]             win_en,
    output logic [NUM_WIN-1:0][PG_W-1:0]   win_base,
    output logic [NUM_WIN-1:0][PG_W-1:0]   win_limit,
    output logic [NUM_WIN-1:0][TC_W-1:0]   win_tc
);

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        // Capture one descriptor when the write addresses this window.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                win_en[w]    <= 1'b0;
                win_base[w]  <= '0;
                win_limit[w] <= '0;
                win_tc[w]    <= '0;
            end else if (wr_en && (wr_idx == WIN_IDX_W'(w))) begin
                win_en[w]    <= wr_enable;
                win_base[w]  <= wr_base;
                win_limit[w] <= wr_limit;
                win_tc[w]    <= wr_tc;
            end
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (win_en == '0));

endmodule

// File: rtl/tcw_win_match.sv
// Module: tcw_win_match
// Compares a page number against every window and picks the matching
// window with the lowest index.
// Assumes: bounds are inclusive. A window whose base is above its limit
// never matches.
module tcw_win_match
    import tcw_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int PG_W    = 20
) (
    input  logic [PG_W-1:0]               page,
    input  logic [NUM_WIN-1:0]            win_en,
    input  logic [NUM_WIN-1:0][PG_W-1:0]  win_base,
    input  logic [NUM_WIN-1:0][PG_W-1:0]  win_limit,
    input  logic [NUM_WIN-1:0][TC_W-1:0]  win_tc,
    output logic                          hit,
    output tc_t                           hit_tc
);

    logic [NUM_WIN-1:0] raw_hit;
    logic [NUM_WIN-1:0] sel_oh;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
        // Range compare for one enabled window.
        assign raw_hit[w] = win_en[w] && (page >= win_base[w]) && (page <= win_limit[w]);
    end

    // Priority select: scan downward so the lowest index wins.
    always_comb begin
        sel_oh = '0;
        hit_tc = '0;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (raw_hit[w]) begin
                sel_oh = '0;
                sel_oh[w] = 1'b1;
                hit_tc = win_tc[w];
            end
        end
    end

    assign hit = |raw_hit;

    // Guard: the selector grants at most one window.
    always_comb begin
        // R5
        sel_oh_chk: assert ($onehot0(sel_oh));
    end

endmodule

// File: rtl/tcw_vc_map.sv
// Module: tcw_vc_map
// Stores the TC-to-VC table and the second-channel enable, looks up the VC
// for a TC, and flags a setup in which no enabled window feeds VC1.
// Assumes: table bit n = 1 sends TCn to VC1. With the channel off, the
// lookup always returns VC0.
module tcw_vc_map
    import tcw_pkg::*;
#(
    parameter int NUM_WIN = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [NUM_TC-1:0]              wr_map,
    input  logic                           wr_vc1_en,
    input  tc_t                            look_tc,
    input  logic [NUM_WIN-1:0]             win_en,
    input  logic [NUM_WIN-1:0][TC_W-1:0]   win_tc,
    output logic                           look_vc,
    output logic                           vc1_on,
    output logic                           cfg_err
);

    logic [NUM_TC-1:0]  map_q;
    logic [NUM_WIN-1:0] feeds_vc1;

    // Table and enable registers; a reset leaves VC1 off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q  <= '0;
            vc1_on <= 1'b0;
        end else if (wr_en) begin
            map_q  <= wr_map;
            vc1_on <= wr_vc1_en;
        end
    end

    // Lookup, gated by the channel enable.
    assign look_vc = vc1_on & map_q[look_tc];

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_feed
        // An enabled window whose TC routes to VC1.
        assign feeds_vc1[w] = win_en[w] & map_q[win_tc[w]];
    end

    // Setup check: the channel is on but no window carries traffic to it.
    assign cfg_err = vc1_on & ~(|feeds_vc1);

    // R10
    err_needs_vc1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> vc1_on);

    // R8
    off_gives_vc0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vc1_on |-> !look_vc);

endmodule

// File: rtl/tcw_mapper.sv
// Module: tcw_mapper (top)
// Classifies upstream requests: address windows give the TC, the table
// gives the VC, and the result is registered for one cycle.
// Assumes: 4 KB pages (PAGE_SHIFT = 12). Non-memory commands skip the
// windows and always get TC0 on VC0.
module tcw_mapper
    import tcw_pkg::*;
#(
    parameter int NUM_WIN    = 4,
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12,
    localparam int PG_W      = ADDR_W - PAGE_SHIFT,
    localparam int WIN_IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic                  req_is_mem,
    input  logic                  cfg_we,
    input  logic [WIN_IDX_W-1:0]  cfg_win,
    input  logic [PG_W-1:0]       cfg_base,
    input  logic [PG_W-1:0]       cfg_limit,
    input  logic                  cfg_en,
    input  logic [TC_W-1:0]       cfg_tc,
    input  logic                  map_we,
    input  logic [NUM_TC-1:0]     map_vec,
    input  logic                  map_vc1_en,
    output logic                  out_valid,
    output logic [TC_W-1:0]       out_tc,
    output logic                  out_vc,
    output logic                  out_hit,
    output logic                  cfg_err
);

    logic [NUM_WIN-1:0]            win_en;
    logic [NUM_WIN-1:0][PG_W-1:0]  win_base;
    logic [NUM_WIN-1:0][PG_W-1:0]  win_limit;
    logic [NUM_WIN-1:0][TC_W-1:0]  win_tc;
    logic [PG_W-1:0]               page;
    logic                          m_hit;
    tc_t                           m_tc;
    logic                          eff_hit;
    tc_t                           eff_tc;
    logic                          look_vc;
    logic                          vc1_on;
    logic                          unused_low;

    assign page       = req_addr[ADDR_W-1:PAGE_SHIFT];
    assign unused_low = ^req_addr[PAGE_SHIFT-1:0];

    tcw_win_regs #(.NUM_WIN(NUM_WIN), .PG_W(PG_W), .WIN_IDX_W(WIN_IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we), .wr_idx(cfg_win), .wr_base(cfg_base), .wr_limit(cfg_limit),
        .wr_enable(cfg_en), .wr_tc(cfg_tc),
        .win_en(win_en), .win_base(win_base), .win_limit(win_limit), .win_tc(win_tc)
    );

    tcw_win_match #(.NUM_WIN(NUM_WIN), .PG_W(PG_W)) u_match (
        .page(page), .win_en(win_en), .win_base(win_base), .win_limit(win_limit),
        .win_tc(win_tc), .hit(m_hit), .hit_tc(m_tc)
    );

    // Only memory requests may take a window label.
    assign eff_hit = req_is_mem & m_hit;
    assign eff_tc  = eff_hit ? m_tc : '0;

    tcw_vc_map #(.NUM_WIN(NUM_WIN)) u_vc (
        .clk(clk), .rst_n(rst_n),
        .wr_en(map_we), .wr_map(map_vec), .wr_vc1_en(map_vc1_en),
        .look_tc(eff_tc), .win_en(win_en), .win_tc(win_tc),
        .look_vc(look_vc), .vc1_on(vc1_on), .cfg_err(cfg_err)
    );

    // Result register; fields are cleared when no request is present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_tc    <= '0;
            out_vc    <= 1'b0;
            out_hit   <= 1'b0;
        end else begin
            out_valid <= req_valid;
            out_tc    <= req_valid ? eff_tc : '0;
            out_vc    <= req_valid & req_is_mem & look_vc;
            out_hit   <= req_valid & eff_hit;
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && out_tc == '0 && !out_vc && !out_hit));
    // R6
    nonmem_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_mem) |=> (out_tc == '0 && !out_vc && !out_hit));
    // R8
    vc0_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vc1_on |=> !out_vc);
    // R4
    miss_tc0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_hit) |-> (out_tc == '0));

endmodule

// File: tb/tb_tcw_mapper.sv
module tb_tcw_mapper;
    import tcw_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_is_mem = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_win = '0;
    logic [19:0] cfg_base = '0;
    logic [19:0] cfg_limit = '0;
    logic        cfg_en = 1'b0;
    logic [2:0]  cfg_tc = '0;
    logic        map_we = 1'b0;
    logic [7:0]  map_vec = '0;
    logic        map_vc1_en = 1'b0;
    logic        out_valid, out_vc, out_hit, cfg_err;
    logic [2:0]  out_tc;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tcw_mapper dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_is_mem(req_is_mem), .cfg_we(cfg_we), .cfg_win(cfg_win),
        .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_en(cfg_en), .cfg_tc(cfg_tc),
        .map_we(map_we), .map_vec(map_vec), .map_vc1_en(map_vc1_en),
        .out_valid(out_valid), .out_tc(out_tc), .out_vc(out_vc), .out_hit(out_hit),
        .cfg_err(cfg_err)
    );

    // Vector: [37] is_mem, [36:5] address, [4:2] TC, [1] VC, [0] hit
    localparam int NV = 11;
    localparam logic [37:0] VEC [NV] = '{
        {1'b1, 32'h0001_0000, 3'd5, 1'b1, 1'b1},
        {1'b1, 32'h0001_FFFF, 3'd5, 1'b1, 1'b1},
        {1'b1, 32'h0000_FFFF, 3'd0, 1'b0, 1'b0},
        {1'b1, 32'h0001_8000, 3'd5, 1'b1, 1'b1},
        {1'b1, 32'h0002_0000, 3'd2, 1'b0, 1'b1},
        {1'b1, 32'h0003_0FFF, 3'd2, 1'b0, 1'b1},
        {1'b1, 32'h0003_1000, 3'd0, 1'b0, 1'b0},
        {1'b1, 32'h0004_0ABC, 3'd7, 1'b1, 1'b1},
        {1'b1, 32'h0008_5000, 3'd0, 1'b0, 1'b0},
        {1'b0, 32'h0001_0000, 3'd0, 1'b0, 1'b0},
        {1'b1, 32'hFFFF_F000, 3'd0, 1'b0, 1'b0}
    };
    localparam string TAGS [NV] = '{"R3", "R3", "R4", "R5", "R3", "R3",
                                    "R4", "R7", "R9", "R6", "R4"};

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic wr_win(input logic [1:0] idx, input logic [19:0] b,
                          input logic [19:0] l, input logic en, input logic [2:0] tc);
        @(negedge clk);
        cfg_we = 1'b1; cfg_win = idx; cfg_base = b; cfg_limit = l; cfg_en = en; cfg_tc = tc;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr_map(input logic [7:0] m, input logic on);
        @(negedge clk);
        map_we = 1'b1; map_vec = m; map_vc1_en = on;
        @(negedge clk);
        map_we = 1'b0;
    endtask

    // Drive at a falling edge; the result is registered at the next rising
    // edge and is sampled at the falling edge after it.
    task automatic do_req(input logic mem, input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_is_mem = mem; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_out(input string tag, input logic [2:0] tc,
                              input logic vc, input logic hit);
        check("R2", "valid", 32'(out_valid), 32'd1);
        check(tag, "tc", 32'(out_tc), 32'(tc));
        check(tag, "vc", 32'(out_vc), 32'(vc));
        check(tag, "hit", 32'(out_hit), 32'(hit));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        check("R1", "cfg_err", 32'(cfg_err), 32'd0);
        check("R2", "idle valid", 32'(out_valid), 32'd0);
        do_req(1'b1, 32'h0001_0000);
        expect_out("R1", 3'd0, 1'b0, 1'b0);

        // Table setup: W0/W1 overlap, W2 is one page, W3 is disabled
        wr_win(2'd0, 20'h00010, 20'h0001F, 1'b1, 3'd5);
        wr_win(2'd1, 20'h00018, 20'h00030, 1'b1, 3'd2);
        wr_win(2'd2, 20'h00040, 20'h00040, 1'b1, 3'd7);
        wr_win(2'd3, 20'h00080, 20'h00090, 1'b0, 3'd6);
        wr_map(8'hA0, 1'b1);
        @(negedge clk);
        check("R10", "cfg_err ok", 32'(cfg_err), 32'd0);

        for (int i = 0; i < NV; i++) begin
            do_req(VEC[i][37], VEC[i][36:5]);
            expect_out(TAGS[i], VEC[i][4:2], VEC[i][1], VEC[i][0]);
        end

        // R2: idle cycle after a request
        @(negedge clk);
        check("R2", "idle valid", 32'(out_valid), 32'd0);

        // R8 / R9: second channel off, labels kept, VC0 everywhere
        wr_map(8'hA0, 1'b0);
        do_req(1'b1, 32'h0001_0000);
        expect_out("R8", 3'd5, 1'b0, 1'b1);
        do_req(1'b1, 32'h0004_0000);
        expect_out("R9", 3'd7, 1'b0, 1'b1);
        check("R10", "cfg_err off", 32'(cfg_err), 32'd0);

        // R10: channel on, no TC routed to VC1
        wr_map(8'h00, 1'b1);
        check("R10", "cfg_err set", 32'(cfg_err), 32'd1);
        // R7: miss uses table bit 0
        wr_map(8'h01, 1'b1);
        check("R10", "cfg_err no feed", 32'(cfg_err), 32'd1);
        do_req(1'b1, 32'h0000_0000);
        expect_out("R7", 3'd0, 1'b1, 1'b0);
        do_req(1'b0, 32'h0000_0000);
        expect_out("R6", 3'd0, 1'b0, 1'b0);

        // R11: rewrite W0 in the same cycle as a request
        wr_map(8'hA0, 1'b1);
        @(negedge clk);
        cfg_we = 1'b1; cfg_win = 2'd0; cfg_base = 20'h00010; cfg_limit = 20'h0001F;
        cfg_en = 1'b1; cfg_tc = 3'd3;
        req_valid = 1'b1; req_is_mem = 1'b1; req_addr = 32'h0001_0000;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        expect_out("R11", 3'd5, 1'b1, 1'b1);
        do_req(1'b1, 32'h0001_0000);
        expect_out("R11", 3'd3, 1'b0, 1'b1);

        finish_run();
    end
endmodule